// File: doc/BRIEF.md
# Interconnect Error Capture Unit

This block sits beside a coherent on-chip interconnect and records the errors the fabric reports. The fabric signals an error with a single-cycle strobe on one or more of four class lines: local access error, coherency violation, unavailable target ID and multicast stash. A source ID, a 40-bit transaction address and a 5-bit capture type travel with each strobe. The block keeps a sticky status bit for each class. It saves the attributes of the first error it sees and keeps them until software releases them. It drives a level interrupt through a per-class enable mask.

Software works through a 32-bit register window with word offsets. It reads the detect register, reads the capture registers while the capture-valid flag is set, and then writes the value it read back to the detect register. That write clears the bits it handled. A separate disable mask can stop a class from being detected at all.

Top module: `icx_err_capture`

## Requirements
- R1: After reset every register offset reads zero and `irq_o` is low. With every register zero, all classes are detected and all interrupts are masked.
- R2: Register word offsets are fixed. 0x00 is detect status: bits 3:0 are the class bits (0 local access, 1 coherency violation, 2 unavailable target, 3 multicast stash), bits 30:26 the capture type, bit 31 capture-valid. 0x04 is the detect-disable mask and 0x08 the interrupt-enable mask, both in bits 3:0. 0x0C holds the source ID in bits 25:18. 0x10 holds address bits 39:32 in bits 7:0, and 0x14 holds address bits 31:0. 0x18 reads zero. Only bits 3:0 of the two masks can be written; the other mask bits read zero.
- R3: An event strobe on a class whose disable bit is clear sets that class's status bit at the next clock edge. The bit then stays set until it is cleared.
- R4: An event on a class whose disable bit is set leaves the status bit and the capture registers unchanged.
- R5: When capture-valid is clear, the first cycle with a detected event stores that cycle's source ID, type and address and sets capture-valid. If several classes fire in that cycle, one capture is made.
- R6: While capture-valid is set, later events still set their status bits, but the stored source ID, type and address do not change.
- R7: `irq_o` is high exactly when some class has both its status bit and its interrupt-enable bit set. It falls in the cycle after the write that clears the last such status bit.
- R8: Writes to 0x00 are write-1-to-clear on bits 3:0 and bit 31, and a 0 leaves a bit unchanged. Clearing bit 31 releases the capture. An event in the same cycle as a clearing write leaves its status bit set.
- R9: While capture-valid is clear, the type field, the source ID and both address registers read zero.
- R10: Writes to offsets 0x0C through 0x1C, and writes to addresses with nonzero low two bits, change no register. Offset 0x1C and misaligned addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 4 | Per-class error strobes, one cycle each |
| evt_src_i | input | 8 | Source ID of the erroring transaction |
| evt_addr_i | input | 40 | Address of the erroring transaction |
| evt_type_i | input | 5 | Capture type of the erroring transaction |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high, with req_i |
| addr_i | input | 5 | Byte offset in the register window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that the fabric attributes are stable while a strobe is high. They also assume that a register write lasts exactly one cycle with `req_i` and `we_i` both high, and that a clearing write is recognised only at byte offset zero. The bench drives every strobe and write for exactly one clock, changing inputs on the falling edge. It sweeps all 256 combinations of the disable and enable masks with all four classes firing together. Directed sequences cover capture freezing, partial clears, release of the capture, and an event that meets a clear in the same cycle.

// File: rtl/icx_err_pkg.sv
package icx_err_pkg;
  typedef enum logic [2:0] {
    RI_DET   = 3'd0,
    RI_DIS   = 3'd1,
    RI_IEN   = 3'd2,
    RI_ATTR  = 3'd3,
    RI_ADH   = 3'd4,
    RI_ADL   = 3'd5,
    RI_ATTR2 = 3'd6,
    RI_NONE  = 3'd7
  } reg_idx_e;

  localparam int unsigned CAP_VLD_BIT = 31;
  localparam int unsigned TYPE_LSB    = 26;
  localparam int unsigned SRC_LSB     = 18;
endpackage

// File: rtl/icx_err_cfg.sv
module icx_err_cfg #(
  parameter int unsigned NUM_CLS = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_dis_i,
  input  logic               wr_ien_i,
  input  logic [NUM_CLS-1:0] wdata_i,
  output logic [NUM_CLS-1:0] dis_o,
  output logic [NUM_CLS-1:0] ien_o
);
  logic [NUM_CLS-1:0] dis_q, ien_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dis_q <= '0;
      ien_q <= '0;
    end else begin
      if (wr_dis_i) dis_q <= wdata_i;
      if (wr_ien_i) ien_q <= wdata_i;
    end
  end

  assign dis_o = dis_q;
  assign ien_o = ien_q;
endmodule

// File: rtl/icx_err_log.sv
module icx_err_log #(
  parameter int unsigned NUM_CLS = 4,
  parameter int unsigned SRC_W   = 8,
  parameter int unsigned TYPE_W  = 5,
  parameter int unsigned EADDR_W = 40
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CLS-1:0] evt_i,
  input  logic [SRC_W-1:0]   evt_src_i,
  input  logic [EADDR_W-1:0] evt_addr_i,
  input  logic [TYPE_W-1:0]  evt_type_i,
  input  logic [NUM_CLS-1:0] dis_i,
  input  logic               clr_i,
  input  logic [NUM_CLS-1:0] clr_mask_i,
  input  logic               clr_cap_i,
  output logic [NUM_CLS-1:0] stat_o,
  output logic               cap_vld_o,
  output logic [SRC_W-1:0]   cap_src_o,
  output logic [EADDR_W-1:0] cap_addr_o,
  output logic [TYPE_W-1:0]  cap_type_o
);
  logic [NUM_CLS-1:0] stat_q, det, clr_bits;
  logic               vld_q, vld_keep, take;
  logic [SRC_W-1:0]   src_q;
  logic [EADDR_W-1:0] addr_q;
  logic [TYPE_W-1:0]  type_q;

  assign det      = evt_i & ~dis_i;
  assign clr_bits = clr_i ? clr_mask_i : '0;
  // a release and a new error in the same cycle capture the new error
  assign vld_keep = vld_q & ~(clr_i & clr_cap_i);
  assign take     = ~vld_keep & (|det);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      vld_q  <= 1'b0;
      src_q  <= '0;
      addr_q <= '0;
      type_q <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_bits) | det;
      vld_q  <= vld_keep | take;
      if (take) begin
        src_q  <= evt_src_i;
        addr_q <= evt_addr_i;
        type_q <= evt_type_i;
      end
    end
  end

  assign stat_o     = stat_q;
  assign cap_vld_o  = vld_q;
  assign cap_src_o  = src_q;
  assign cap_addr_o = addr_q;
  assign cap_type_o = type_q;
endmodule

// File: rtl/icx_err_rdmux.sv
module icx_err_rdmux
  import icx_err_pkg::*;
#(
  parameter int unsigned NUM_CLS = 4,
  parameter int unsigned SRC_W   = 8,
  parameter int unsigned TYPE_W  = 5,
  parameter int unsigned EADDR_W = 40,
  parameter int unsigned DATA_W  = 32
) (
  input  reg_idx_e           idx_i,
  input  logic [NUM_CLS-1:0] stat_i,
  input  logic               cap_vld_i,
  input  logic [SRC_W-1:0]   cap_src_i,
  input  logic [EADDR_W-1:0] cap_addr_i,
  input  logic [TYPE_W-1:0]  cap_type_i,
  input  logic [NUM_CLS-1:0] dis_i,
  input  logic [NUM_CLS-1:0] ien_i,
  output logic [DATA_W-1:0]  rdata_o
);
  localparam int unsigned ADH_W = EADDR_W - DATA_W;

  logic [SRC_W-1:0]   src_v;
  logic [EADDR_W-1:0] addr_v;
  logic [TYPE_W-1:0]  type_v;

  // capture fields are hidden while nothing is held
  assign src_v  = cap_vld_i ? cap_src_i  : '0;
  assign addr_v = cap_vld_i ? cap_addr_i : '0;
  assign type_v = cap_vld_i ? cap_type_i : '0;

  always_comb begin
    rdata_o = '0;
    unique case (idx_i)
      RI_DET: begin
        rdata_o[NUM_CLS-1:0]        = stat_i;
        rdata_o[TYPE_LSB +: TYPE_W] = type_v;
        rdata_o[CAP_VLD_BIT]        = cap_vld_i;
      end
      RI_DIS:  rdata_o[NUM_CLS-1:0]       = dis_i;
      RI_IEN:  rdata_o[NUM_CLS-1:0]       = ien_i;
      RI_ATTR: rdata_o[SRC_LSB +: SRC_W]  = src_v;
      RI_ADH:  rdata_o[ADH_W-1:0]         = addr_v[EADDR_W-1:DATA_W];
      RI_ADL:  rdata_o                    = addr_v[DATA_W-1:0];
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/icx_err_capture.sv
module icx_err_capture
  import icx_err_pkg::*;
#(
  parameter int unsigned NUM_CLS = 4,
  parameter int unsigned SRC_W   = 8,
  parameter int unsigned TYPE_W  = 5,
  parameter int unsigned EADDR_W = 40,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned RAW     = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CLS-1:0] evt_i,
  input  logic [SRC_W-1:0]   evt_src_i,
  input  logic [EADDR_W-1:0] evt_addr_i,
  input  logic [TYPE_W-1:0]  evt_type_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [RAW-1:0]     addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o
);
  reg_idx_e           idx;
  logic               wr_en, wr_det, wr_dis, wr_ien;
  logic [NUM_CLS-1:0] stat_q, dis_q, ien_q;
  logic               cap_vld_q;
  logic [SRC_W-1:0]   cap_src_q;
  logic [EADDR_W-1:0] cap_addr_q;
  logic [TYPE_W-1:0]  cap_type_q;
  logic               unused_wdata;

  assign idx    = (addr_i[1:0] == 2'b00) ? reg_idx_e'(addr_i[RAW-1:2]) : RI_NONE;
  assign wr_en  = req_i & we_i;
  assign wr_det = wr_en & (idx == RI_DET);
  assign wr_dis = wr_en & (idx == RI_DIS);
  assign wr_ien = wr_en & (idx == RI_IEN);

  assign unused_wdata = ^wdata_i[CAP_VLD_BIT-1:NUM_CLS];

  icx_err_cfg #(.NUM_CLS(NUM_CLS)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_dis_i (wr_dis),
    .wr_ien_i (wr_ien),
    .wdata_i  (wdata_i[NUM_CLS-1:0]),
    .dis_o    (dis_q),
    .ien_o    (ien_q)
  );

  icx_err_log #(
    .NUM_CLS(NUM_CLS), .SRC_W(SRC_W), .TYPE_W(TYPE_W), .EADDR_W(EADDR_W)
  ) u_log (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt_i),
    .evt_src_i  (evt_src_i),
    .evt_addr_i (evt_addr_i),
    .evt_type_i (evt_type_i),
    .dis_i      (dis_q),
    .clr_i      (wr_det),
    .clr_mask_i (wdata_i[NUM_CLS-1:0]),
    .clr_cap_i  (wdata_i[CAP_VLD_BIT]),
    .stat_o     (stat_q),
    .cap_vld_o  (cap_vld_q),
    .cap_src_o  (cap_src_q),
    .cap_addr_o (cap_addr_q),
    .cap_type_o (cap_type_q)
  );

  icx_err_rdmux #(
    .NUM_CLS(NUM_CLS), .SRC_W(SRC_W), .TYPE_W(TYPE_W),
    .EADDR_W(EADDR_W), .DATA_W(DATA_W)
  ) u_rdmux (
    .idx_i      (idx),
    .stat_i     (stat_q),
    .cap_vld_i  (cap_vld_q),
    .cap_src_i  (cap_src_q),
    .cap_addr_i (cap_addr_q),
    .cap_type_i (cap_type_q),
    .dis_i      (dis_q),
    .ien_i      (ien_q),
    .rdata_o    (rdata_o)
  );

  assign irq_o = |(stat_q & ien_q);
endmodule

// File: rtl/icx_err_capture_chk.sv
module icx_err_capture_chk #(
  parameter int unsigned NUM_CLS = 4,
  parameter int unsigned SRC_W   = 8,
  parameter int unsigned EADDR_W = 40,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned RAW     = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_CLS-1:0] evt_i,
  input logic [SRC_W-1:0]   evt_src_i,
  input logic [EADDR_W-1:0] evt_addr_i,
  input logic               req_i,
  input logic               we_i,
  input logic [RAW-1:0]     addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic               irq_o,
  input logic [NUM_CLS-1:0] stat_q,
  input logic [NUM_CLS-1:0] dis_q,
  input logic [NUM_CLS-1:0] ien_q,
  input logic               cap_vld_q,
  input logic [SRC_W-1:0]   cap_src_q,
  input logic [EADDR_W-1:0] cap_addr_q
);
  logic clr_wr;
  assign clr_wr = req_i & we_i & (addr_i == '0);

  // R3
  evt_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(evt_i & ~dis_q)) |=> ((stat_q & $past(evt_i & ~dis_q)) == $past(evt_i & ~dis_q)));

  // R4
  masked_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_q & ~$past(stat_q) & $past(dis_q)) == '0));

  // R5
  cap_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_vld_q && (|(evt_i & ~dis_q))) |=>
      (cap_vld_q && cap_src_q == $past(evt_src_i) && cap_addr_q == $past(evt_addr_i)));

  // R6
  cap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_vld_q && !(clr_wr && wdata_i[DATA_W-1])) |=>
      (cap_vld_q && $stable(cap_src_q) && $stable(cap_addr_q)));

  // R7
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q == '0) |-> !irq_o);

  // R7
  irq_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr && (&wdata_i[NUM_CLS-1:0]) && !(|evt_i)) |=> !irq_o);
endmodule

bind icx_err_capture icx_err_capture_chk #(
  .NUM_CLS(NUM_CLS), .SRC_W(SRC_W), .EADDR_W(EADDR_W), .DATA_W(DATA_W), .RAW(RAW)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .evt_i      (evt_i),
  .evt_src_i  (evt_src_i),
  .evt_addr_i (evt_addr_i),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .irq_o      (irq_o),
  .stat_q     (stat_q),
  .dis_q      (dis_q),
  .ien_q      (ien_q),
  .cap_vld_q  (cap_vld_q),
  .cap_src_q  (cap_src_q),
  .cap_addr_q (cap_addr_q)
);

// File: tb/tb_icx_err_capture.sv
module tb_icx_err_capture;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] O_DET = 5'h00, O_DIS = 5'h04, O_IEN = 5'h08, O_ATTR = 5'h0C,
                         O_ADH = 5'h10, O_ADL = 5'h14, O_ATTR2 = 5'h18, O_GAP = 5'h1C;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [3:0]  evt = '0;
  logic [7:0]  esrc = '0;
  logic [39:0] eaddr = '0;
  logic [4:0]  etype = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int n_cmp = 0, n_bad = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  icx_err_capture dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .evt_src_i(esrc), .evt_addr_i(eaddr),
    .evt_type_i(etype), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h exp %08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic pulse(input logic [3:0] e, input logic [7:0] s, input logic [39:0] ad,
                       input logic [4:0] t);
    @(negedge clk);
    evt = e; esrc = s; eaddr = ad; etype = t;
    @(negedge clk);
    evt = '0;
  endtask

  function automatic logic [31:0] det_val(input logic v, input logic [4:0] t, input logic [3:0] s);
    return {v, (v ? t : 5'd0), 22'd0, s};
  endfunction

  initial begin
    logic [7:0] sa;
    logic [39:0] aa;
    #(CLK_PERIOD*2 + 2);
    // R1 reset state
    rd(O_DET, 0, "R1 det"); rd(O_DIS, 0, "R1 dis"); rd(O_IEN, 0, "R1 ien");
    rd(O_ATTR, 0, "R1 attr"); rd(O_ADH, 0, "R1 adh"); rd(O_ADL, 0, "R1 adl");
    rd(O_ATTR2, 0, "R1 attr2");
    chk("R1 irq", {31'd0, irq}, 0);
    rst_n = 1'b1;

    // R2 R3 R4 R5 R7 sweep over masks with all classes firing together
    for (int d = 0; d < 16; d++) begin
      wr(O_DIS, {28'hFFFFFFF, 4'(d)});
      rd(O_DIS, 32'(d), "R2 dis readback");
      for (int e = 0; e < 16; e++) begin
        logic [3:0] st;
        logic       v;
        wr(O_IEN, {28'hFFFFFFF, 4'(e)});
        if (d == 0) rd(O_IEN, 32'(e), "R2 ien readback");
        wr(O_DET, 32'hFFFFFFFF);
        sa = 8'(d*16 + e);
        aa = {sa ^ 8'h5A, 32'h1000_0000 + 32'(d*977 + e*131)};
        pulse(4'hF, sa, aa, 5'(d + e));
        st = 4'hF & ~4'(d);
        v  = (st != 0);
        rd(O_DET, det_val(v, 5'(d + e), st), "R3/R4/R5 det");
        chk("R7 irq sweep", {31'd0, irq}, {31'd0, |(st & 4'(e))});
        rd(O_ATTR, v ? {6'd0, sa, 18'd0} : 32'd0, "R5 attr src");
        rd(O_ADH, v ? {24'd0, aa[39:32]} : 32'd0, "R5 addr hi");
        rd(O_ADL, v ? aa[31:0] : 32'd0, "R5 addr lo");
      end
    end

    // R6 freeze
    wr(O_DIS, 0); wr(O_IEN, 0); wr(O_DET, 32'hFFFFFFFF);
    rd(O_DET, 0, "R8 full clear");
    pulse(4'b0001, 8'hA1, 40'hAB_1234_5678, 5'd7);
    pulse(4'b0100, 8'h3C, 40'h01_0000_0040, 5'd19);
    rd(O_DET, det_val(1, 5'd7, 4'b0101), "R6 det");
    rd(O_ATTR, {6'd0, 8'hA1, 18'd0}, "R6 attr");
    rd(O_ADH, 32'h0000_00AB, "R6 adh");
    rd(O_ADL, 32'h1234_5678, "R6 adl");

    // R8 partial clear keeps capture
    wr(O_DET, 32'h1);
    rd(O_DET, det_val(1, 5'd7, 4'b0100), "R8 partial");
    // R8 release capture, R9 fields hidden
    wr(O_DET, 32'h8000_0000);
    rd(O_DET, det_val(0, 5'd0, 4'b0100), "R8 release");
    rd(O_ATTR, 0, "R9 attr"); rd(O_ADH, 0, "R9 adh"); rd(O_ADL, 0, "R9 adl");
    pulse(4'b1000, 8'h55, 40'hEE_CAFE_0000, 5'd30);
    rd(O_DET, det_val(1, 5'd30, 4'b1100), "R5 recapture");
    rd(O_ATTR, {6'd0, 8'h55, 18'd0}, "R5 recapture attr");

    // R8 event meets clear in same cycle
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = O_DET; wdata = 32'h0000_000F;
    evt = 4'b0010; esrc = 8'h11; eaddr = 40'h0; etype = 5'd1;
    @(negedge clk);
    req = 1'b0; we = 1'b0; wdata = '0; evt = '0;
    rd(O_DET, det_val(1, 5'd30, 4'b0010), "R8 set wins");

    // R7 irq and fall after clear
    chk("R7 irq masked", {31'd0, irq}, 0);
    wr(O_IEN, 32'h2);
    chk("R7 irq on", {31'd0, irq}, 1);
    wr(O_DET, 32'h2);
    chk("R7 irq off", {31'd0, irq}, 0);

    // R10 read-only and unmapped writes
    wr(O_ATTR, 32'hFFFFFFFF); wr(O_ADH, 32'hFFFFFFFF); wr(O_ADL, 32'hFFFFFFFF);
    wr(O_ATTR2, 32'hFFFFFFFF); wr(O_GAP, 32'hFFFFFFFF); wr(5'h05, 32'hFFFFFFFF);
    wr(5'h01, 32'hFFFFFFFF);
    rd(O_ATTR, {6'd0, 8'h55, 18'd0}, "R10 attr");
    rd(O_ADH, 32'h0000_00EE, "R10 adh");
    rd(O_ADL, 32'hCAFE_0000, "R10 adl");
    rd(O_ATTR2, 0, "R10 attr2");
    rd(O_GAP, 0, "R10 gap");
    rd(5'h05, 0, "R10 misaligned read");
    rd(O_DIS, 0, "R10 dis");
    rd(O_DET, det_val(1, 5'd30, 4'b0000), "R10 det");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule